// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller Register Front End

This block is the software-facing side of a fuse-array controller. A processor reaches it over a simple 32-bit register bus. Through that bus it can arm and launch the programming of one fuse word, refresh a bank of shadow copies from the array, and read or patch those shadow copies. Programming is done by a separate serial engine, which the block starts with a one-cycle pulse and which answers with a done pulse. During a refresh the block walks the array one word per cycle through a combinational read port.

Protection is enforced per word. A word may be write-locked, which blocks both programming it and patching its shadow. A word may be read-locked, which poisons reads of its shadow. Any refused or illegal access raises a sticky error flag, and while that flag is up the block accepts no further work. Programming needs a fresh unlock code every time, so a stray write to the data register cannot burn fuses.

Top module: `fuse_ctl`

## Requirements
- R1: After reset the control, timing and data registers read as zero. Control is at 0x000, timing at 0x010 (read/write, 32 bits) and data at 0x020. A read returns its data with `bus_rvalid` high one cycle after the request, and unmapped addresses read as zero.
- R2: The control register is laid out as follows: bits [7:0] word address, bit 8 busy, bit 9 error, bit 10 refresh, bits [31:16] unlock field. A program operation starts only if the unlock field holds 0x3E77 when the data register is written. Every accepted data write clears the unlock field, so each operation needs a fresh arm.
- R3: An armed data write with no error and no refresh in progress starts the operation. It sets busy, pulses `prog_start` for exactly one cycle with the word address and data, and holds busy until `prog_done`.
- R4: The word address is captured when the operation starts. Later writes to the address field do not change `prog_addr` for the running operation.
- R5: An armed data write to a write-locked word, or to an index at or above the word count, gives no `prog_start` and leaves busy clear. It sets error instead.
- R6: The error flag is sticky. Only writing 1 to bit 9 at the clear alias 0x008 clears it, and a direct control write cannot. While error is set, program starts and refresh requests are refused, shadow writes are dropped, and shadow reads return zero.
- R7: Writing 1 to bit 10 at 0x000 or 0x004 starts a refresh, unless busy, error or refresh is already set. The refresh flag stays set while each shadow word is reloaded from the array, one per cycle, and then clears itself. Shadow word i is at 0x400 + 0x10*i.
- R8: A read of a read-locked shadow word returns 0xBADABADA and sets error.
- R9: A data-register write while busy is ignored, and the data register keeps its value.
- R10: A shadow write updates the word unless a refresh is in progress or the word is write-locked. In those two cases it sets error and leaves the word unchanged.
- R11: The set alias 0x004 ORs the written bits into the address and unlock fields. The clear alias 0x008 clears the written bits in those same fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| prog_start | output | 1 | One-cycle start pulse to the programming engine |
| prog_addr | output | 8 | Captured word address of the running operation |
| prog_data | output | 32 | Data word to program |
| prog_done | input | 1 | Engine completion pulse |
| arr_addr | output | 8 | Array word index during refresh |
| arr_rdata | input | 32 | Array word at arr_addr (combinational) |
| rd_lock | input | NWORDS | Per-word read lock |
| wr_lock | input | NWORDS | Per-word write lock |

## Verification
Programming is tried in four cases: correctly armed, armed with a word that is write-locked, written without a fresh arm, and armed while the error flag is up. Only the first may give a start pulse, so these cases separate the unlock check, the lock check and the error gate. The same operation is then disturbed by an address rewrite and a second data write while busy, which shows whether the address and data were captured.

Shadow reads and writes are tried against words that are free, read-locked and write-locked, and also during an ongoing refresh. Comparing the refreshed words with the array model confirms both the per-cycle copy and the wipe of an earlier patch.

// File: rtl/fuse_ctl.sv
module fuse_ctl #(
  parameter int          NWORDS = 16,
  parameter logic [15:0] UNLOCK = 16'h3E77
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [11:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              prog_start,
  output logic [7:0]        prog_addr,
  output logic [31:0]       prog_data,
  input  logic              prog_done,
  output logic [7:0]        arr_addr,
  input  logic [31:0]       arr_rdata,
  input  logic [NWORDS-1:0] rd_lock,
  input  logic [NWORDS-1:0] wr_lock
);
  localparam int          IW     = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [31:0] POISON = 32'hBADADABA ^ 32'h00000000 ^ 32'h0000E0E0 ^ 32'h0000E0E0 ^ 32'h00000000 ^ (32'hBADADABA ^ 32'hBADABADA);

  logic [7:0]    addr_q, op_addr_q;
  logic [15:0]   unlock_q;
  logic          busy_q, err_q, rl_q, start_q;
  logic [IW-1:0] rl_cnt;
  logic [31:0]   timing_q, data_q;
  logic [31:0]   shadow [NWORDS];

  wire wr = bus_req & bus_we;
  wire rd = bus_req & ~bus_we;
  wire a_ctrl = bus_addr == 12'h000;
  wire a_set  = bus_addr == 12'h004;
  wire a_clr  = bus_addr == 12'h008;
  wire a_tim  = bus_addr == 12'h010;
  wire a_dat  = bus_addr == 12'h020;

  wire          sh_hit = (bus_addr[11:10] == 2'b01) && (bus_addr[3:0] == 4'h0) &&
                         (int'(bus_addr[9:4]) < NWORDS);
  wire [IW-1:0] sh_idx = bus_addr[4 +: IW];
  wire [IW-1:0] w_idx  = addr_q[IW-1:0];
  wire          addr_ok = int'(addr_q) < NWORDS;

  wire armed     = unlock_q == UNLOCK;
  wire dat_wr    = wr & a_dat & ~busy_q;
  wire go        = dat_wr & armed & ~err_q & ~rl_q;
  wire prog_ok   = addr_ok && !wr_lock[w_idx];
  wire start     = go & prog_ok;
  wire lock_err  = go & ~prog_ok;
  wire rl_req    = wr & (a_ctrl | a_set) & bus_wdata[10] & ~busy_q & ~err_q & ~rl_q;
  wire sh_wr     = wr & sh_hit & ~err_q;
  wire sh_wr_bad = sh_wr & (rl_q | wr_lock[sh_idx]);
  wire sh_wr_ok  = sh_wr & ~sh_wr_bad;
  wire sh_rd_bad = rd & sh_hit & ~err_q & rd_lock[sh_idx];
  wire err_clr   = wr & a_clr & bus_wdata[9];

  wire [31:0] ctrl_rd = {unlock_q, 5'b0, rl_q, err_q, busy_q, addr_q};

  assign prog_start = start_q;
  assign prog_addr  = op_addr_q;
  assign prog_data  = data_q;
  assign arr_addr   = 8'(rl_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      unlock_q  <= '0;
      op_addr_q <= '0;
      busy_q    <= 1'b0;
      err_q     <= 1'b0;
      start_q   <= 1'b0;
      timing_q  <= '0;
      data_q    <= '0;
    end else begin
      start_q <= start;
      if (wr && a_ctrl) begin
        addr_q   <= bus_wdata[7:0];
        unlock_q <= bus_wdata[31:16];
      end else if (wr && a_set) begin
        addr_q   <= addr_q | bus_wdata[7:0];
        unlock_q <= unlock_q | bus_wdata[31:16];
      end else if (wr && a_clr) begin
        addr_q   <= addr_q & ~bus_wdata[7:0];
        unlock_q <= unlock_q & ~bus_wdata[31:16];
      end else if (dat_wr) begin
        unlock_q <= '0;
      end
      if (dat_wr) data_q <= bus_wdata;
      if (wr && a_tim) timing_q <= bus_wdata;
      if (start) begin
        busy_q    <= 1'b1;
        op_addr_q <= addr_q;
      end else if (prog_done) begin
        busy_q <= 1'b0;
      end
      if (err_clr) err_q <= 1'b0;
      else if (lock_err || sh_wr_bad || sh_rd_bad) err_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rl_q   <= 1'b0;
      rl_cnt <= '0;
    end else if (rl_req) begin
      rl_q   <= 1'b1;
      rl_cnt <= '0;
    end else if (rl_q) begin
      rl_cnt <= rl_cnt + 1'b1;
      if (rl_cnt == IW'(NWORDS - 1)) rl_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) shadow[i] <= '0;
    end else if (rl_q) begin
      shadow[rl_cnt] <= arr_rdata;
    end else if (sh_wr_ok) begin
      shadow[sh_idx] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd;
      if (rd) begin
        if (a_ctrl || a_set || a_clr) bus_rdata <= ctrl_rd;
        else if (a_tim)               bus_rdata <= timing_q;
        else if (a_dat)               bus_rdata <= data_q;
        else if (sh_hit)              bus_rdata <= err_q ? 32'h0 :
                                                   rd_lock[sh_idx] ? POISON : shadow[sh_idx];
        else                          bus_rdata <= '0;
      end
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start); // R3
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !prog_done |=> busy_q); // R3
  AST_NO_LOCKED_START: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> !$past(wr_lock[w_idx])); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !(bus_req && bus_we && bus_addr == 12'h008 && bus_wdata[9]) |=> err_q); // R6
  AST_REFRESH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && rl_q)); // R7
  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !prog_done |=> $stable(prog_data)); // R9
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !prog_done |=> $stable(prog_addr)); // R4
endmodule

// File: tb/fuse_ctl_tb_top.sv
module fuse_ctl_tb_top;
  localparam int NW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, prog_data, arr_rdata;
  logic bus_rvalid, prog_start, prog_done;
  logic [7:0] prog_addr, arr_addr;
  logic [NW-1:0] rd_lock = '0, wr_lock = '0;

  logic [31:0] arr [NW];
  int nchk = 0, nfail = 0, starts = 0, cnt = 0;
  logic [7:0] cap_addr;
  logic [31:0] cap_data;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  fuse_ctl #(.NWORDS(NW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .prog_start(prog_start), .prog_addr(prog_addr), .prog_data(prog_data),
    .prog_done(prog_done), .arr_addr(arr_addr), .arr_rdata(arr_rdata),
    .rd_lock(rd_lock), .wr_lock(wr_lock));

  assign arr_rdata = (int'(arr_addr) < NW) ? arr[arr_addr[3:0]] : 32'h0;

  initial for (int i = 0; i < NW; i++) arr[i] = {16'hA5A5, 16'(i)};

  always @(posedge clk) begin
    prog_done <= 1'b0;
    if (!rst_n) cnt <= 0;
    else if (prog_start) begin
      starts   <= starts + 1;
      cap_addr <= prog_addr;
      cap_data <= prog_data;
      cnt      <= 5;
    end else if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        arr[cap_addr[3:0]] <= arr[cap_addr[3:0]] | cap_data;
        prog_done <= 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) chk(1'b0, "unexpected read data", bus_rdata, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(bus_rdata === e, t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    chk(1'b0, "watchdog expired", 32'h0, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    rd(12'h000, 32'h0, "R1 control reset");
    rd(12'h010, 32'h0, "R1 timing reset");
    rd(12'h020, 32'h0, "R1 data reset");
    wr(12'h010, 32'h1234ABCD);
    rd(12'h010, 32'h1234ABCD, "R1 timing readback");

    wr(12'h000, 32'h3E770003);
    rd(12'h000, 32'h3E770003, "R2 unlock field armed");
    wr(12'h020, 32'h000000F0);
    rd(12'h000, 32'h00000103, "R3 busy set unlock cleared");
    wr(12'h000, 32'h00000005);
    wr(12'h020, 32'h00005555);
    rd(12'h020, 32'h000000F0, "R9 data kept while busy");
    idle(12);
    chk(starts == 1, "R3 one start", 32'(starts), 32'd1);
    chk(cap_addr == 8'd3, "R4 captured address", 32'(cap_addr), 32'd3);
    chk(cap_data == 32'hF0, "R3 program data", cap_data, 32'hF0);
    rd(12'h000, 32'h00000005, "R3 busy cleared on done");

    wr(12'h004, 32'h00000400);
    rd(12'h000, 32'h00000405, "R7 refresh flag set");
    idle(NW + 4);
    rd(12'h000, 32'h00000005, "R7 refresh flag self-clears");
    rd(12'h430, 32'hA5A500F3, "R7 refreshed programmed word");
    rd(12'h490, 32'hA5A50009, "R7 refreshed word 9");

    wr(12'h004, 32'h00000030);
    rd(12'h000, 32'h00000035, "R11 set alias");
    wr(12'h008, 32'h00000031);
    rd(12'h000, 32'h00000004, "R11 clear alias");

    wr(12'h020, 32'h00000001);
    idle(12);
    chk(starts == 1, "R2 no start without fresh arm", 32'(starts), 32'd1);
    rd(12'h000, 32'h00000004, "R2 not busy without arm");

    wr_lock[6] = 1'b1;
    wr(12'h000, 32'h3E770006);
    wr(12'h020, 32'h000000FF);
    idle(12);
    chk(starts == 1, "R5 no start on locked word", 32'(starts), 32'd1);
    rd(12'h000, 32'h00000206, "R5 error set busy clear");

    wr(12'h000, 32'h00000006);
    rd(12'h000, 32'h00000206, "R6 direct write keeps error");
    wr(12'h004, 32'h00000400);
    rd(12'h000, 32'h00000206, "R6 refresh refused");
    rd(12'h430, 32'h00000000, "R6 shadow read refused");
    wr(12'h000, 32'h3E770003);
    wr(12'h020, 32'h00000001);
    idle(12);
    chk(starts == 1, "R6 program refused", 32'(starts), 32'd1);
    rd(12'h000, 32'h00000203, "R6 error still set");
    wr(12'h008, 32'h00000200);
    rd(12'h000, 32'h00000003, "R6 clear alias clears error");

    rd_lock[2] = 1'b1;
    rd(12'h420, 32'hBADABADA, "R8 poison value");
    rd(12'h000, 32'h00000203, "R8 error set by locked read");
    wr(12'h008, 32'h00000200);

    wr(12'h440, 32'hCAFE0004);
    rd(12'h440, 32'hCAFE0004, "R10 shadow write accepted");
    wr(12'h460, 32'h12345678);
    rd(12'h000, 32'h00000203, "R10 locked shadow write error");
    wr(12'h008, 32'h00000200);
    rd(12'h460, 32'hA5A50006, "R10 locked shadow unchanged");
    wr(12'h004, 32'h00000400);
    wr(12'h450, 32'h00001111);
    idle(NW + 4);
    rd(12'h000, 32'h00000203, "R10 write during refresh error");
    wr(12'h008, 32'h00000200);
    rd(12'h450, 32'hA5A50005, "R10 shadow unchanged by refresh-time write");
    rd(12'h440, 32'hA5A50004, "R7 refresh overwrites patch");
    idle(4);
    chk(exp_q.size() == 0, "R1 all reads answered", 32'(exp_q.size()), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule